// File: doc/BRIEF.md
# Dual-Region Memory Arbiter with DMA Priority

This block sits between two requesters, a processor port and a DMA port, and two single-cycle synchronous memories. It splits a 24-bit byte address space into a low shared window, which both requesters may reach, and an upper processor-only window that starts directly above it and ends at a configurable limit. Any address above that limit is invalid for the processor. For DMA, every address outside the shared window is invalid.

The shared memory has a single access slot per cycle. When both requesters want that slot in the same cycle, DMA takes it and the processor waits. A starvation counter guarantees that a processor request which has waited a fixed number of consecutive cycles gets the next slot. Processor accesses to the upper window go straight to the second memory without arbitration, so they proceed in parallel with shared-window DMA traffic.

Each requester port uses a valid/ready handshake. Ready is asserted in the cycle the request is accepted. A response strobe follows exactly one cycle later and carries the read data and an error bit. Invalid requests are accepted without touching either memory, and they return an error with all-ones data.

Top module: `dual_region_mem_arbiter`

## Requirements
- R1: An address at or below 0x1FFFFF decodes to the shared window. An address from 0x200000 up to `PRIV_END` (default 0x9FFFFF) decodes to the processor-only window. A processor address above `PRIV_END` is invalid.
- R2: When the processor and DMA both request the shared window in one cycle and the processor has waited fewer than `STARVE_LIMIT` cycles, DMA is accepted, the processor's ready stays low, and the shared memory port carries the DMA address.
- R3: A processor shared-window request that has been refused for `STARVE_LIMIT` (default 16) consecutive cycles is accepted in the next cycle, even while DMA requests. In that cycle DMA's ready is low.
- R4: A processor request to the processor-only window is accepted in the same cycle its valid rises, whatever DMA is doing.
- R5: A processor-only-window request and a shared-window DMA request in the same cycle are both accepted, and both memory enables are high.
- R6: A DMA request at or above 0x200000 is accepted with no shared memory enable. Its response carries error = 1 and all-ones read data.
- R7: A processor request above `PRIV_END` is accepted with neither memory enable. Its response carries error = 1 and all-ones read data.
- R8: Every accepted request produces a response strobe exactly one cycle later, and only then. A valid read returns the addressed memory word with error = 0.
- R9: While reset is asserted and in the first cycle after it, no response strobe or error is raised, and with no request present neither memory enable is high.
- R10: The shared memory address is the low 21 address bits. The processor-only memory address is the request address minus 0x200000.
- R11: A write is forwarded with its data and write enable to the memory of its window. An invalid write reaches no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_addr | input | 24 | Processor byte address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_rvalid | output | 1 | Processor response strobe |
| cpu_rdata | output | 16 | Processor read data |
| cpu_err | output | 1 | Processor response error |
| dma_valid | input | 1 | DMA request valid |
| dma_addr | input | 24 | DMA byte address |
| dma_we | input | 1 | DMA write enable |
| dma_wdata | input | 16 | DMA write data |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_rvalid | output | 1 | DMA response strobe |
| dma_rdata | output | 16 | DMA read data |
| dma_err | output | 1 | DMA response error |
| shm_en | output | 1 | Shared memory enable |
| shm_we | output | 1 | Shared memory write enable |
| shm_addr | output | 21 | Shared memory address |
| shm_wdata | output | 16 | Shared memory write data |
| shm_rdata | input | 16 | Shared memory read data, one cycle after enable |
| pvm_en | output | 1 | Processor-only memory enable |
| pvm_we | output | 1 | Processor-only memory write enable |
| pvm_addr | output | 24 | Processor-only memory address (offset from window base) |
| pvm_wdata | output | 16 | Processor-only memory write data |
| pvm_rdata | input | 16 | Processor-only memory read data, one cycle after enable |

## Verification
The checker watches every cycle for the following: the shared slot is never given to both ports at once, DMA wins contention until the starvation window runs out, processor-only requests never wait, and invalid requests raise no enable and lead to an error response. It also checks that every acceptance is followed by exactly one response strobe. Only the bench scenarios can show that the processor is admitted in exactly the seventeenth cycle of a DMA burst, that read data matches what was earlier written through the correct window, and that addresses are translated correctly across a sweep of boundary and scattered addresses.

// File: rtl/mra_pkg.sv
package mra_pkg;
  typedef enum logic [1:0] {
    RG_SHARED  = 2'd0,
    RG_PRIVATE = 2'd1,
    RG_INVALID = 2'd2
  } region_e;
endpackage

// File: rtl/mra_region_decode.sv
module mra_region_decode
  import mra_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                SHARED_AW = 21,
  parameter logic [ADDR_W-1:0] UPPER_END = 'h9F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] SHARED_END = ADDR_W'((64'd1 << SHARED_AW) - 64'd1);

  always_comb begin
    if (addr <= SHARED_END)     region = RG_SHARED;
    else if (addr <= UPPER_END) region = RG_PRIVATE;
    else                        region = RG_INVALID;
  end
endmodule

// File: rtl/mra_shared_arbiter.sv
module mra_shared_arbiter #(
  parameter int STARVE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic dma_req,
  output logic cpu_gnt,
  output logic dma_gnt
);
  localparam int CW = $clog2(STARVE_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STARVE_LIMIT);

  logic [CW-1:0] wait_q, wait_d;
  logic          wait_en;
  logic          force_cpu;

  always_comb begin
    force_cpu = cpu_req && (wait_q == LIMIT);
    dma_gnt   = dma_req && !force_cpu;
    cpu_gnt   = cpu_req && !dma_gnt;
    wait_en   = cpu_req || (wait_q != '0);
    if (!cpu_req || cpu_gnt) wait_d = '0;
    else                     wait_d = wait_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end
endmodule

// File: rtl/mra_resp_track.sv
module mra_resp_track
  import mra_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  region_e src,
  output logic    rvalid,
  output region_e src_q
);
  logic    rvalid_d;
  region_e src_d;
  logic    src_en;

  always_comb begin
    rvalid_d = accept;
    src_d    = src;
    src_en   = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= RG_INVALID;
    else if (src_en) src_q <= src_d;
  end
endmodule

// File: rtl/dual_region_mem_arbiter.sv
module dual_region_mem_arbiter
  import mra_pkg::*;
#(
  parameter int                ADDR_W       = 24,
  parameter int                DATA_W       = 16,
  parameter int                SHARED_AW    = 21,
  parameter logic [ADDR_W-1:0] PRIV_END     = 'h9F_FFFF,
  parameter int                STARVE_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_err,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_ready,
  output logic              dma_rvalid,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_err,
  output logic                 shm_en,
  output logic                 shm_we,
  output logic [SHARED_AW-1:0] shm_addr,
  output logic [DATA_W-1:0]    shm_wdata,
  input  logic [DATA_W-1:0]    shm_rdata,
  output logic              pvm_en,
  output logic              pvm_we,
  output logic [ADDR_W-1:0] pvm_addr,
  output logic [DATA_W-1:0] pvm_wdata,
  input  logic [DATA_W-1:0] pvm_rdata
);
  localparam logic [ADDR_W-1:0] SHARED_END = ADDR_W'((64'd1 << SHARED_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] PRIV_BASE  = SHARED_END + ADDR_W'(1);

  region_e cpu_rg, dma_rg;
  region_e cpu_src_q, dma_src_q;
  logic    cpu_sh_req, dma_sh_req;
  logic    cpu_gnt, dma_gnt;

  // Processor sees both windows; DMA decode collapses the upper window so
  // anything above the shared window is invalid for it.
  mra_region_decode #(.ADDR_W(ADDR_W), .SHARED_AW(SHARED_AW), .UPPER_END(PRIV_END))
    u_cpu_dec (.addr(cpu_addr), .region(cpu_rg));

  mra_region_decode #(.ADDR_W(ADDR_W), .SHARED_AW(SHARED_AW), .UPPER_END(SHARED_END))
    u_dma_dec (.addr(dma_addr), .region(dma_rg));

  always_comb begin
    cpu_sh_req = cpu_valid && (cpu_rg == RG_SHARED);
    dma_sh_req = dma_valid && (dma_rg == RG_SHARED);
  end

  mra_shared_arbiter #(.STARVE_LIMIT(STARVE_LIMIT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_sh_req),
    .dma_req (dma_sh_req),
    .cpu_gnt (cpu_gnt),
    .dma_gnt (dma_gnt)
  );

  // Acceptance: shared requests need a grant, everything else goes at once.
  always_comb begin
    cpu_ready = cpu_valid && ((cpu_rg != RG_SHARED) || cpu_gnt);
    dma_ready = dma_valid && ((dma_rg != RG_SHARED) || dma_gnt);
  end

  // Shared memory port: owner chosen by the arbiter.
  always_comb begin
    shm_en = cpu_gnt || dma_gnt;
    if (dma_gnt) begin
      shm_we    = dma_we;
      shm_addr  = dma_addr[SHARED_AW-1:0];
      shm_wdata = dma_wdata;
    end else begin
      shm_we    = cpu_gnt && cpu_we;
      shm_addr  = cpu_addr[SHARED_AW-1:0];
      shm_wdata = cpu_wdata;
    end
  end

  // Processor-only memory port: no arbitration.
  always_comb begin
    pvm_en    = cpu_valid && (cpu_rg == RG_PRIVATE);
    pvm_we    = pvm_en && cpu_we;
    pvm_addr  = cpu_addr - PRIV_BASE;
    pvm_wdata = cpu_wdata;
  end

  mra_resp_track u_cpu_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (cpu_ready),
    .src    (cpu_rg),
    .rvalid (cpu_rvalid),
    .src_q  (cpu_src_q)
  );

  mra_resp_track u_dma_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (dma_ready),
    .src    (dma_rg),
    .rvalid (dma_rvalid),
    .src_q  (dma_src_q)
  );

  always_comb begin
    unique case (cpu_src_q)
      RG_SHARED:  cpu_rdata = shm_rdata;
      RG_PRIVATE: cpu_rdata = pvm_rdata;
      default:    cpu_rdata = '1;
    endcase
    cpu_err = cpu_rvalid && (cpu_src_q == RG_INVALID);
    dma_rdata = (dma_src_q == RG_SHARED) ? shm_rdata : '1;
    dma_err   = dma_rvalid && (dma_src_q != RG_SHARED);
  end
endmodule

// File: rtl/dual_region_mem_arbiter_chk.sv
module dual_region_mem_arbiter_chk #(
  parameter int                ADDR_W       = 24,
  parameter int                DATA_W       = 16,
  parameter int                SHARED_AW    = 21,
  parameter logic [ADDR_W-1:0] PRIV_END     = 'h9F_FFFF,
  parameter int                STARVE_LIMIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_err,
  input logic              dma_valid,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              dma_ready,
  input logic              dma_rvalid,
  input logic [DATA_W-1:0] dma_rdata,
  input logic              dma_err,
  input logic              shm_en,
  input logic              pvm_en
);
  localparam logic [ADDR_W-1:0] SH_END = ADDR_W'((64'd1 << SHARED_AW) - 64'd1);
  localparam int CW = $clog2(STARVE_LIMIT + 2);

  logic cpu_sh, cpu_pv, cpu_bad, dma_sh;
  logic [CW-1:0] waited;

  assign cpu_sh  = cpu_addr <= SH_END;
  assign cpu_pv  = (cpu_addr > SH_END) && (cpu_addr <= PRIV_END);
  assign cpu_bad = cpu_addr > PRIV_END;
  assign dma_sh  = dma_addr <= SH_END;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waited <= '0;
    else if (cpu_valid && cpu_sh && !cpu_ready) waited <= waited + CW'(1);
    else waited <= '0;
  end

  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready && cpu_sh && dma_valid && dma_ready && dma_sh));

  a_r2_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_sh && dma_valid && dma_sh && (waited < CW'(STARVE_LIMIT)))
      |-> (dma_ready && !cpu_ready));

  a_r3_starve_bound: assert property (@(posedge clk) disable iff (!rst_n)
    waited <= CW'(STARVE_LIMIT));

  a_r4_upper_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_pv) |-> (cpu_ready && pvm_en));

  a_r6_dma_high_err: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_sh) |=> (dma_rvalid && dma_err && (dma_rdata == '1)));

  a_r7_cpu_bad_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_bad) |-> (cpu_ready && !pvm_en));

  a_r7_cpu_bad_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_bad) |=> (cpu_err && (cpu_rdata == '1)));

  a_r8_cpu_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> cpu_rvalid);

  a_r8_cpu_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready) |=> !cpu_rvalid);

  a_r8_dma_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready) |=> dma_rvalid);

  a_r9_shm_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    shm_en |-> ((cpu_valid && cpu_sh && cpu_ready) || (dma_valid && dma_sh && dma_ready)));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_quiet: assert (!cpu_rvalid && !dma_rvalid && !cpu_err && !dma_err);
    end
  end
endmodule

bind dual_region_mem_arbiter dual_region_mem_arbiter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED_AW(SHARED_AW),
  .PRIV_END(PRIV_END), .STARVE_LIMIT(STARVE_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
  .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_ready(dma_ready),
  .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata), .dma_err(dma_err),
  .shm_en(shm_en), .pvm_en(pvm_en)
);

// File: tb/dual_region_mem_arbiter_tb_top.sv
module dual_region_mem_arbiter_tb_top;
  localparam logic [23:0] PEND = 24'h9F_FFFF;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic        cpu_valid, cpu_we, cpu_ready, cpu_rvalid, cpu_err;
  logic [23:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        dma_valid, dma_we, dma_ready, dma_rvalid, dma_err;
  logic [23:0] dma_addr;
  logic [15:0] dma_wdata, dma_rdata;
  logic        shm_en, shm_we, pvm_en, pvm_we;
  logic [20:0] shm_addr;
  logic [23:0] pvm_addr;
  logic [15:0] shm_wdata, shm_rdata, pvm_wdata, pvm_rdata;

  dual_region_mem_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_we(dma_we), .dma_wdata(dma_wdata),
    .dma_ready(dma_ready), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata), .dma_err(dma_err),
    .shm_en(shm_en), .shm_we(shm_we), .shm_addr(shm_addr), .shm_wdata(shm_wdata),
    .shm_rdata(shm_rdata),
    .pvm_en(pvm_en), .pvm_we(pvm_we), .pvm_addr(pvm_addr), .pvm_wdata(pvm_wdata),
    .pvm_rdata(pvm_rdata)
  );

  // Memory models: 64 words each, aliased on the low address bits.
  logic [15:0] sh_mem [64];
  logic [15:0] pv_mem [64];
  always @(posedge clk) begin
    if (shm_en) begin
      if (shm_we) sh_mem[shm_addr[5:0]] <= shm_wdata;
      shm_rdata <= sh_mem[shm_addr[5:0]];
    end
    if (pvm_en) begin
      if (pvm_we) pv_mem[pvm_addr[5:0]] <= pvm_wdata;
      pvm_rdata <= pv_mem[pvm_addr[5:0]];
    end
  end

  logic [15:0] ref_sh [64];
  logic [15:0] ref_pv [64];
  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int region_of(input logic [23:0] a);
    if (a <= 24'h1F_FFFF) return 0;
    if (a <= PEND)        return 1;
    return 2;
  endfunction

  function automatic logic [23:0] pick_addr(input int i);
    case (i)
      0: return 24'h00_0000;
      1: return 24'h00_003F;
      2: return 24'h1F_FFFF;
      3: return 24'h20_0000;
      4: return 24'h20_003F;
      5: return PEND;
      6: return PEND + 24'h1;
      7: return 24'hFF_FFFF;
      default: return 24'((i * 32'h0006_7A3D + 32'h1234) & 32'hFF_FFFF);
    endcase
  endfunction

  task automatic cpu_op(input logic [23:0] a, input logic we, input logic [15:0] wd);
    int rg;
    logic [15:0] exp;
    rg = region_of(a);
    exp = (rg == 0) ? ref_sh[a[5:0]] : (rg == 1) ? ref_pv[a[5:0]] : 16'hFFFF;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
    #3;
    chk(cpu_ready === 1'b1, "R1", "cpu accepted", cpu_ready, 1);
    if (rg == 0)
      chk(shm_en && !pvm_en && shm_we == we && shm_addr == a[20:0] && (!we || shm_wdata == wd),
          "R10/R11", "shared port", {shm_en, pvm_en, shm_we, shm_addr}, {2'b10, we, a[20:0]});
    else if (rg == 1)
      chk(pvm_en && !shm_en && pvm_we == we && pvm_addr == a - 24'h20_0000 && (!we || pvm_wdata == wd),
          "R10/R11", "upper port", {pvm_en, shm_en, pvm_we, pvm_addr}, {2'b10, we, a - 24'h20_0000});
    else
      chk(!shm_en && !pvm_en, "R7", "no enable on invalid", {shm_en, pvm_en}, 0);
    if (we && rg == 0) ref_sh[a[5:0]] = wd;
    if (we && rg == 1) ref_pv[a[5:0]] = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    #3;
    chk(cpu_rvalid && cpu_err == (rg == 2), (rg == 2) ? "R7" : "R8", "cpu response",
        {cpu_rvalid, cpu_err}, {1'b1, rg == 2});
    if (!we)
      chk(cpu_rdata == exp, (rg == 2) ? "R7" : "R8", "cpu read data", cpu_rdata, exp);
  endtask

  task automatic dma_op(input logic [23:0] a, input logic we, input logic [15:0] wd);
    bit ok_rg;
    logic [15:0] exp;
    ok_rg = (a <= 24'h1F_FFFF);
    exp = ok_rg ? ref_sh[a[5:0]] : 16'hFFFF;
    @(negedge clk);
    dma_valid = 1'b1; dma_addr = a; dma_we = we; dma_wdata = wd;
    #3;
    chk(dma_ready === 1'b1, "R1", "dma accepted", dma_ready, 1);
    if (ok_rg)
      chk(shm_en && shm_we == we && shm_addr == a[20:0] && (!we || shm_wdata == wd),
          "R10/R11", "dma shared port", {shm_en, shm_we, shm_addr}, {1'b1, we, a[20:0]});
    else
      chk(!shm_en && !pvm_en, "R6", "no enable for high dma", {shm_en, pvm_en}, 0);
    if (we && ok_rg) ref_sh[a[5:0]] = wd;
    @(negedge clk);
    dma_valid = 1'b0;
    #3;
    chk(dma_rvalid && dma_err == !ok_rg, ok_rg ? "R8" : "R6", "dma response",
        {dma_rvalid, dma_err}, {1'b1, !ok_rg});
    if (!we)
      chk(dma_rdata == exp, ok_rg ? "R8" : "R6", "dma read data", dma_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int waits;
    int bad;
    for (int i = 0; i < 64; i++) begin ref_sh[i] = '0; ref_pv[i] = '0; end
    cpu_valid = 0; cpu_addr = '0; cpu_we = 0; cpu_wdata = '0;
    dma_valid = 0; dma_addr = '0; dma_we = 0; dma_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(!cpu_rvalid && !dma_rvalid && !cpu_err && !dma_err && !shm_en && !pvm_en,
        "R9", "quiet in reset", {cpu_rvalid, dma_rvalid, cpu_err, dma_err, shm_en, pvm_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(!cpu_rvalid && !dma_rvalid && !shm_en && !pvm_en, "R9", "quiet after reset",
        {cpu_rvalid, dma_rvalid, shm_en, pvm_en}, 0);

    // R1/R7/R8/R10/R11: processor sweep, write then read each address.
    for (int i = 0; i < 40; i++) begin
      cpu_op(pick_addr(i), 1'b1, 16'hA500 ^ 16'(i * 37));
      cpu_op(pick_addr(i), 1'b0, 16'h0000);
    end

    // R6/R8: DMA sweep.
    for (int i = 0; i < 24; i++) begin
      dma_op(pick_addr(i), 1'b1, 16'h3C00 ^ 16'(i * 11));
      dma_op(pick_addr(i), 1'b0, 16'h0000);
    end

    // R2: one cycle of contention, then the processor gets the slot.
    @(negedge clk);
    cpu_valid = 1; cpu_addr = 24'h30; cpu_we = 1; cpu_wdata = 16'h1111;
    dma_valid = 1; dma_addr = 24'h31; dma_we = 1; dma_wdata = 16'h2222;
    #3;
    chk(dma_ready && !cpu_ready && shm_addr == 21'h31, "R2", "dma wins contention",
        {dma_ready, cpu_ready, shm_addr}, {2'b10, 21'h31});
    ref_sh[6'h31] = 16'h2222;
    @(negedge clk);
    dma_valid = 0;
    #3;
    chk(cpu_ready && shm_addr == 21'h30 && dma_rvalid && !dma_err, "R2", "cpu next free cycle",
        {cpu_ready, shm_addr, dma_rvalid, dma_err}, {1'b1, 21'h30, 2'b10});
    ref_sh[6'h30] = 16'h1111;
    @(negedge clk);
    cpu_valid = 0;
    #3;
    chk(cpu_rvalid && !cpu_err, "R8", "cpu response after stall", {cpu_rvalid, cpu_err}, 2'b10);
    cpu_op(24'h30, 1'b0, 16'h0);

    // R3: continuous DMA reads starve the processor for exactly 16 cycles.
    waits = 0; bad = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_addr = 24'h10; cpu_we = 0;
    dma_valid = 1; dma_addr = 24'h100; dma_we = 0;
    for (int k = 0; k < 40; k++) begin
      #3;
      if (cpu_ready) break;
      if (!dma_ready || shm_addr != dma_addr[20:0]) bad++;
      waits++;
      @(negedge clk);
      dma_addr = 24'h101 + 24'(k);
    end
    chk(waits == 16, "R3", "cycles refused", waits, 16);
    chk(bad == 0, "R2", "dma owned slot while cpu waited", bad, 0);
    chk(cpu_ready && !dma_ready && shm_en && shm_addr == 21'h10, "R3", "forced cpu grant",
        {cpu_ready, dma_ready, shm_en, shm_addr}, {3'b101, 21'h10});
    @(negedge clk);
    cpu_valid = 0; dma_addr = 24'h200;
    #3;
    chk(cpu_rvalid && cpu_rdata == ref_sh[6'h10], "R3", "starved read data", cpu_rdata, ref_sh[6'h10]);
    chk(dma_ready, "R3", "dma resumes", dma_ready, 1);

    // R4/R5: upper-window processor access in parallel with DMA.
    @(negedge clk);
    cpu_valid = 1; cpu_addr = 24'h20_0040; cpu_we = 1; cpu_wdata = 16'h5A5A;
    dma_valid = 1; dma_addr = 24'h20; dma_we = 1; dma_wdata = 16'hC3C3;
    #3;
    chk(cpu_ready, "R4", "upper access without wait", cpu_ready, 1);
    chk(dma_ready && pvm_en && shm_en && shm_addr == 21'h20 && pvm_addr == 24'h40, "R5",
        "parallel service", {dma_ready, pvm_en, shm_en, shm_addr}, {3'b111, 21'h20});
    ref_pv[6'h00] = 16'h5A5A; ref_sh[6'h20] = 16'hC3C3;
    @(negedge clk);
    cpu_valid = 0; dma_valid = 0;
    #3;
    chk(cpu_rvalid && dma_rvalid && !cpu_err && !dma_err, "R5", "both responses",
        {cpu_rvalid, dma_rvalid, cpu_err, dma_err}, 4'b1100);
    cpu_op(24'h20_0040, 1'b0, 16'h0);
    dma_op(24'h20, 1'b0, 16'h0);

    #3;
    chk(!cpu_rvalid && !dma_rvalid && !shm_en && !pvm_en, "R8", "idle after traffic",
        {cpu_rvalid, dma_rvalid, shm_en, pvm_en}, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule